// File: doc/BRIEF.md
# Single-Bit Clear/Set/Toggle/Test Unit

This execution unit acts on one bit of one register word. A request names the target register, gives that register's current value and a bit position, and picks one of four operations. Clear, set and toggle return the modified word with a write enable, so the register file can store it. Test leaves the word alone, raises no write enable and loads the zero flag from the chosen bit.

The operation comes from two instruction bits. The family bit picks the clear family or the set family. The alternate bit turns clear into test and set into toggle. The bit position is a full index into the word, so any bit of any register can be reached. The unit does not care where the word came from, so a memory form can pass a fetched word through the same datapath.

All results are registered. Each request takes one clock.

Top module: `bitop_unit`

## Requirements
- R1: While reset is active, and in the first cycle after it, `wb_data` is 0, `wb_en` is 0, `wb_sel` is 0 and `z_flag` is 0.
- R2: A request with `fam_set`=0 and `ext_alt`=0 clears the bit of `reg_val` at position `bit_idx`. `wb_data` carries the result and `wb_en`=1.
- R3: A request with `fam_set`=1 and `ext_alt`=0 sets the selected bit. `wb_data` carries the result and `wb_en`=1.
- R4: A request with `fam_set`=1 and `ext_alt`=1 inverts the selected bit. `wb_data` carries the result and `wb_en`=1.
- R5: A request with `fam_set`=0 and `ext_alt`=1 is a test. `wb_en` stays 0 and `wb_data` carries `reg_val` unchanged.
- R6: After a test, `z_flag` is 1 if the selected bit was 0, and 0 if it was 1.
- R7: Clear, set and toggle requests leave `z_flag` unchanged.
- R8: `wb_sel` carries the `reg_sel` of the last accepted request. All 16 values from 0 to 15 can be used.
- R9: Every `bit_idx` from 0 to 31 can be used. No bit other than the selected one differs between `reg_val` and `wb_data`.
- R10: In a cycle with `in_valid`=0, `wb_en` is 0 in the next cycle, and `wb_data`, `wb_sel` and `z_flag` keep their values.
- R11: The results of a request accepted at one rising clock edge appear on the outputs right after that edge. `wb_en` stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present in this cycle |
| fam_set | input | 1 | Operation family: 0 = clear/test, 1 = set/toggle |
| ext_alt | input | 1 | Alternate form: test in place of clear, toggle in place of set |
| bit_idx | input | 5 | Position of the bit to operate on |
| reg_sel | input | 4 | Number of the target register |
| reg_val | input | 32 | Current value of the target word |
| wb_data | output | 32 | Word to write back |
| wb_en | output | 1 | Write-back strobe, one cycle |
| wb_sel | output | 4 | Register number for the write-back |
| z_flag | output | 1 | Zero flag, loaded by tests |

## Verification
The bench builds two copies of the block with the default 32-bit word and 16 registers. One copy uses the shifter form of the mask generator and the other uses the comparator-array form. Both copies get the same stimulus and are checked against the same expected values, so a fault in either mask variant is caught. With the full-width defaults, the vectors reach bit positions 0, 15, 16 and 31, registers 0 and 15, and operations whose result equals the input word (clearing a clear bit, setting a set bit).

// File: rtl/bitop_pkg.sv
package bitop_pkg;

   typedef enum logic [1:0] {
      OP_CLR = 2'd0,
      OP_SET = 2'd1,
      OP_TGL = 2'd2,
      OP_TST = 2'd3
   } bitop_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
   import bitop_pkg::*;
(
   input  logic   fam_set,
   input  logic   ext_alt,
   output bitop_t op
);

   always_comb begin
      unique case ({fam_set, ext_alt})
         2'b00:   op = OP_CLR;
         2'b01:   op = OP_TST;
         2'b10:   op = OP_SET;
         default: op = OP_TGL;
      endcase
   end

endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
   parameter int DATA_W     = 32,
   parameter int MASK_STYLE = 0,
   localparam int IDX_W     = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] mask
);

   if (MASK_STYLE == 0) begin : g_shift
      always_comb mask = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
   end else if (MASK_STYLE == 1) begin : g_cmp
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign mask[i] = (idx == IDX_W'(i));
      end
   end else begin : g_bad_style
      $error("bitop_mask: MASK_STYLE must be 0 or 1");
   end

   // R9: exactly one bit position is selected
   always_comb begin
      if (!$isunknown(idx))
         assert_mask_single_R9: assert ($countones(mask) == 1)
            else $error("mask not one-hot");
   end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
   import bitop_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  bitop_t            op,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] dout,
   output logic              bit_val,
   output logic              writes
);

   always_comb begin
      bit_val = |(din & mask);
      writes  = 1'b1;
      unique case (op)
         OP_CLR: dout = din & ~mask;
         OP_SET: dout = din | mask;
         OP_TGL: dout = din ^ mask;
         default: begin
            dout   = din;
            writes = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NREG       = 16,
   parameter int MASK_STYLE = 0,
   localparam int IDX_W     = $clog2(DATA_W),
   localparam int SEL_W     = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              fam_set,
   input  logic              ext_alt,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_val,
   output logic [DATA_W-1:0] wb_data,
   output logic              wb_en,
   output logic [SEL_W-1:0]  wb_sel,
   output logic              z_flag
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bitop_unit: DATA_W must be a power of two, at least 2");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("bitop_unit: NREG must be a power of two, at least 2");
   end

   bitop_t            op;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] result;
   logic              bit_val;
   logic              writes;

   bitop_decode u_dec (
      .fam_set (fam_set),
      .ext_alt (ext_alt),
      .op      (op)
   );

   bitop_mask #(
      .DATA_W     (DATA_W),
      .MASK_STYLE (MASK_STYLE)
   ) u_mask (
      .idx  (bit_idx),
      .mask (mask)
   );

   bitop_alu #(
      .DATA_W (DATA_W)
   ) u_alu (
      .op      (op),
      .din     (reg_val),
      .mask    (mask),
      .dout    (result),
      .bit_val (bit_val),
      .writes  (writes)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_data <= '0;
         wb_en   <= 1'b0;
         wb_sel  <= '0;
         z_flag  <= 1'b0;
      end else begin
         wb_en <= in_valid & writes;
         if (in_valid) begin
            wb_data <= result;
            wb_sel  <= reg_sel;
            if (!writes)
               z_flag <= ~bit_val;
         end
      end
   end

   // R5: a test never raises the write strobe
   assert_test_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fam_set == 1'b0 && ext_alt == 1'b1) |=> !wb_en);

   // R6: Z after a test reflects the inverse of the tested port bit
   assert_test_zflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fam_set == 1'b0 && ext_alt == 1'b1)
         |=> (z_flag == !$past(reg_val[bit_idx])));

   // R7: modifying operations leave Z alone
   assert_z_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(fam_set == 1'b0 && ext_alt == 1'b1)) |=> $stable(z_flag));

   // R9: a write-back differs from the source word in at most one bit
   assert_single_bit_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) |-> ($countones(wb_data ^ $past(reg_val)) <= 1));

   // R10: idle cycles hold every output and drop the strobe
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!wb_en && $stable(wb_data) && $stable(wb_sel) && $stable(z_flag)));

   // R11: the write strobe lasts a single cycle unless a new request follows
   assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && !in_valid) |=> !wb_en);

endmodule

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        fam_set = 1'b0;
   logic        ext_alt = 1'b0;
   logic [4:0]  bit_idx = '0;
   logic [3:0]  reg_sel = '0;
   logic [31:0] reg_val = '0;

   logic [31:0] wb_data, wb_data_b;
   logic        wb_en, wb_en_b;
   logic [3:0]  wb_sel, wb_sel_b;
   logic        z_flag, z_flag_b;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bitop_unit #(.DATA_W(32), .NREG(16), .MASK_STYLE(0)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fam_set(fam_set),
      .ext_alt(ext_alt), .bit_idx(bit_idx), .reg_sel(reg_sel), .reg_val(reg_val),
      .wb_data(wb_data), .wb_en(wb_en), .wb_sel(wb_sel), .z_flag(z_flag));

   bitop_unit #(.DATA_W(32), .NREG(16), .MASK_STYLE(1)) dut_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fam_set(fam_set),
      .ext_alt(ext_alt), .bit_idx(bit_idx), .reg_sel(reg_sel), .reg_val(reg_val),
      .wb_data(wb_data_b), .wb_en(wb_en_b), .wb_sel(wb_sel_b), .z_flag(z_flag_b));

   typedef struct packed {
      logic        fam;
      logic        alt;
      logic [4:0]  idx;
      logic [3:0]  sel;
      logic [31:0] val;
      logic [31:0] exp_data;
      logic        exp_en;
      logic        exp_z;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 5'd0,  4'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, 1'b0}, // R2 R9 bit 0
      '{1'b1, 1'b0, 5'd31, 4'd15, 32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0}, // R3 R8 reg 15
      '{1'b1, 1'b1, 5'd4,  4'd0,  32'h0000_00F0, 32'h0000_00E0, 1'b1, 1'b0}, // R4 reg 0
      '{1'b0, 1'b1, 5'd7,  4'd5,  32'h0000_007F, 32'h0000_007F, 1'b0, 1'b1}, // R5 R6 bit clear
      '{1'b1, 1'b1, 5'd8,  4'd9,  32'h1234_5678, 32'h1234_5778, 1'b1, 1'b1}, // R4 R7
      '{1'b0, 1'b1, 5'd31, 4'd1,  32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0}, // R6 bit set
      '{1'b0, 1'b0, 5'd16, 4'd2,  32'h0001_0000, 32'h0000_0000, 1'b1, 1'b0}, // R2 R9 bit 16
      '{1'b1, 1'b0, 5'd15, 4'd14, 32'h0000_8000, 32'h0000_8000, 1'b1, 1'b0}, // R3 already set
      '{1'b0, 1'b1, 5'd16, 4'd7,  32'hFFFE_FFFF, 32'hFFFE_FFFF, 1'b0, 1'b1}, // R6 lone zero
      '{1'b0, 1'b0, 5'd23, 4'd8,  32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1}, // R2 R7 already clear
      '{1'b0, 1'b1, 5'd0,  4'd6,  32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R5 R6
      '{1'b1, 1'b1, 5'd31, 4'd12, 32'h8000_0001, 32'h0000_0001, 1'b1, 1'b0}  // R4 top bit
   };

   task automatic check1(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_out(input string req, input logic [31:0] ed, input logic ee,
                            input logic [3:0] es, input logic ez);
      check1(req, "wb_data", wb_data, ed);
      check1(req, "wb_en", {31'd0, wb_en}, {31'd0, ee});
      check1(req, "wb_sel", {28'd0, wb_sel}, {28'd0, es});
      check1(req, "z_flag", {31'd0, z_flag}, {31'd0, ez});
      check1(req, "alt wb_data", wb_data_b, ed);
      check1(req, "alt wb_en", {31'd0, wb_en_b}, {31'd0, ee});
      check1(req, "alt wb_sel", {28'd0, wb_sel_b}, {28'd0, es});
      check1(req, "alt z_flag", {31'd0, z_flag_b}, {31'd0, ez});
   endtask

   task automatic issue(input logic f, input logic a, input logic [4:0] i,
                        input logic [3:0] s, input logic [31:0] v);
      @(negedge clk);
      in_valid = 1'b1; fam_set = f; ext_alt = a; bit_idx = i; reg_sel = s; reg_val = v;
      @(negedge clk);
      in_valid = 1'b0; fam_set = 1'b0; ext_alt = 1'b0; bit_idx = '0; reg_sel = '0; reg_val = '0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      // R1: reset values
      repeat (3) @(negedge clk);
      check_out("R1", 32'h0, 1'b0, 4'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1", 32'h0, 1'b0, 4'd0, 1'b0);

      // table walk: R2..R9, R11 (result right after the accepting edge)
      for (int k = 0; k < NVEC; k++) begin
         issue(VECS[k].fam, VECS[k].alt, VECS[k].idx, VECS[k].sel, VECS[k].val);
         check_out("R2-R9 table", VECS[k].exp_data, VECS[k].exp_en, VECS[k].sel, VECS[k].exp_z);
      end

      // R11: strobe drops after one cycle; R10: idle holds outputs
      issue(1'b1, 1'b0, 5'd20, 4'd11, 32'h0000_0000);
      check_out("R11", 32'h0010_0000, 1'b1, 4'd11, 1'b0);
      @(negedge clk);
      check_out("R11", 32'h0010_0000, 1'b0, 4'd11, 1'b0);
      // R10: inputs change while in_valid low and must be ignored
      fam_set = 1'b0; ext_alt = 1'b1; bit_idx = 5'd3; reg_sel = 4'd4; reg_val = 32'hFFFF_FFF0;
      repeat (3) @(negedge clk);
      check_out("R10", 32'h0010_0000, 1'b0, 4'd11, 1'b0);

      // R6 then R7: Z set by test, kept through a toggle and a set
      issue(1'b0, 1'b1, 5'd9, 4'd13, 32'hFFFF_FDFF);
      check_out("R6", 32'hFFFF_FDFF, 1'b0, 4'd13, 1'b1);
      issue(1'b1, 1'b1, 5'd1, 4'd10, 32'hAAAA_AAAA);
      check_out("R7", 32'hAAAA_AAA8, 1'b1, 4'd10, 1'b1);
      issue(1'b1, 1'b0, 5'd30, 4'd15, 32'h0000_0000);
      check_out("R7", 32'h4000_0000, 1'b1, 4'd15, 1'b1);

      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R1", 32'h0, 1'b0, 4'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule